// File: doc/BRIEF.md
# Boot-block write protection checker

This block decides whether a requested modifying operation on a 1 MB byte-wide flash array may go ahead. It maps a 20-bit byte address onto 23 blocks of two sizes (eight 8 KB blocks at the bottom, the first two being boot blocks, then fifteen 64 KB blocks). It holds one lock bit per block and a single permanent lock bit, and it weighs these against a write-protect level input, a supply-low indicator and a device reset input. One cycle after a request, it answers with allow or deny and the status error bits that the sequencer must set.

The same block carries out the lock-bit commands: set the lock of one block, clear all block locks, and set the permanent lock. An identifier-read address port returns the stored lock bit of the block that contains it. A per-block "erasable" vector lets an erase sequencer walk the array during a full chip erase and skip protected blocks. The lock bits are volatile here and come out of reset from a parameter value. That value is all zeros by default.

Top module: `wprot_guard`

## Requirements
- R1: Block index from address: 0x00000–0x01FFF is block 0 and 0x02000–0x03FFF is block 1 (the boot blocks). 0x04000–0x0FFFF is blocks 2–7, 8 KB each. 0x10000–0xFFFFF is blocks 8–22, 64 KB each. `id_lock` shows the stored lock bit of the block that holds `id_addr`, and `perm_lock` shows the permanent lock bit.
- R2: After `rst_n` is asserted, every block lock bit equals `LOCK_INIT` (default 0), `perm_lock` equals `PERM_INIT` (default 0) and `resp_valid` is low.
- R3: Operation codes on `req_op`: 1 byte write, 2 block erase, 3 full chip erase, 4 set block lock, 5 clear all block locks, 6 set permanent lock. A request with a valid code gives exactly one cycle of `resp_valid` in the cycle after `req_valid`. Codes 0 and 7 give no response and change nothing. When the request is allowed, `resp_err` is 0.
- R4: Status bit positions in `resp_err` are: bit 1 lock, bit 3 supply, bit 4 program failure, bit 5 erase failure. A byte write to an effectively locked block is denied with 0x12, and a block erase of such a block is denied with 0x22.
- R5: While `boot_wr_en` is 0, blocks 0 and 1 count as locked whatever their lock bits hold. While it is 1, they follow their lock bits. Blocks 2–22 never depend on it, and it does not change any stored bit.
- R6: With `supply_low` high (and `hold_rst` low), every operation is denied and no state changes. Block erase, chip erase and clear-locks report 0x28. Byte write, set-lock and set-permanent report 0x18.
- R7: With `hold_rst` high, every operation is denied with `resp_err` = 0 and no state changes. This takes priority over `supply_low`.
- R8: An allowed set-lock sets only the lock bit of the block that holds `req_addr`. An allowed clear-locks clears all 23 lock bits in one step.
- R9: Once the permanent lock bit is set it never clears. While it is set, set-lock is denied with 0x12 and clear-locks with 0x22, and the lock bits do not change.
- R10: Bit i of `erasable` is 1 when block i is not effectively locked. Full chip erase is denied with 0x22 only when no block is erasable; otherwise it is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| hold_rst | input | 1 | Device reset input; denies all operations while high |
| supply_low | input | 1 | Programming supply below its lockout level |
| boot_wr_en | input | 1 | Write-protect level; 0 forces the boot blocks locked |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | 20 | Target byte address of the request |
| id_addr | input | 20 | Address for identifier lock readback |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_allow | output | 1 | Operation may proceed |
| resp_err | output | 8 | Status bits to set on denial |
| id_lock | output | 1 | Stored lock bit of the block holding `id_addr` |
| perm_lock | output | 1 | Permanent lock bit |
| erasable | output | 23 | Per-block not-effectively-locked vector |

## Verification
A lock bit stored in the wrong place would show up at `id_lock` as soon as the address port points at that block. It would also show up in `erasable`, combinationally, in the cycle after the update. A wrong block decode or a wrong priority between reset, supply and lock shows up in the very next response as a wrong allow or a wrong `resp_err` code. To make such faults visible, the bench sweeps both ends of every block, both write-protect levels and every operation code against a model of the lock bits that it keeps itself. It also checks that the permanent bit cannot fall, so any stray clear is caught at the next readback.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_BYTE_WR    = 3'd1,
    OP_BLK_ERASE  = 3'd2,
    OP_CHIP_ERASE = 3'd3,
    OP_SET_LOCK   = 3'd4,
    OP_CLR_LOCKS  = 3'd5,
    OP_SET_PERM   = 3'd6,
    OP_RSVD       = 3'd7
  } op_e;

  localparam int ST_LOCK_BIT   = 1;
  localparam int ST_SUPPLY_BIT = 3;
  localparam int ST_PROG_BIT   = 4;
  localparam int ST_ERASE_BIT  = 5;

  // Operations whose failure is reported through the erase-failure bit
  function automatic logic is_erase_class(input op_e op);
    return (op == OP_BLK_ERASE) || (op == OP_CHIP_ERASE) || (op == OP_CLR_LOCKS);
  endfunction

  function automatic logic is_real_op(input op_e op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

  // Denial code: cause bit plus the failure class bit of the operation
  function automatic logic [7:0] deny_code(input op_e op, input int cause_bit);
    logic [7:0] c;
    c = 8'h00;
    c[cause_bit] = 1'b1;
    if (is_erase_class(op)) c[ST_ERASE_BIT] = 1'b1;
    else                    c[ST_PROG_BIT]  = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/wprot_blk_decode.sv
module wprot_blk_decode #(
  parameter int ADDR_W    = 20,
  parameter int NUM_SMALL = 8,
  parameter int NUM_BOOT  = 2,
  parameter int NUM_BLK   = 23,
  parameter int SMALL_SH  = 13,
  parameter int BIG_SH    = 16,
  localparam int IDX_W    = $clog2(NUM_BLK)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              is_boot
);

  localparam logic [31:0] SMALL_SPAN = 32'(NUM_SMALL) << SMALL_SH;
  localparam logic [31:0] SKIP_BIG   = SMALL_SPAN >> BIG_SH;

  // Small blocks sit at the bottom; the big blocks start above them
  function automatic logic [IDX_W-1:0] to_index(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    if (w < SMALL_SPAN) return IDX_W'(w >> SMALL_SH);
    return IDX_W'(32'(NUM_SMALL) + (w >> BIG_SH) - SKIP_BIG);
  endfunction

  always_comb begin
    idx     = to_index(addr);
    is_boot = (32'(idx) < 32'(NUM_BOOT));
  end

endmodule

// File: rtl/wprot_lock_store.sv
module wprot_lock_store #(
  parameter int NUM_BLK = 23,
  parameter logic [NUM_BLK-1:0] LOCK_INIT = '0,
  parameter logic PERM_INIT = 1'b0,
  localparam int IDX_W = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic               perm_en,
  output logic [NUM_BLK-1:0] lock_q,
  output logic               perm_q
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLK; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    lock_q[gi] <= LOCK_INIT[gi];
        else if (clr_en)                               lock_q[gi] <= 1'b0;
        else if (set_en && (32'(set_idx) == 32'(gi)))  lock_q[gi] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       perm_q <= PERM_INIT;
    else if (perm_en) perm_q <= 1'b1;
  end

  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (lock_q == '0));

  assert_set_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> lock_q[$past(set_idx)]);

endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wprot_pkg::*;
#(
  parameter int NUM_BLK  = 23,
  parameter int NUM_BOOT = 2,
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               req_valid,
  input  op_e                op,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_BLK-1:0] lock_q,
  input  logic               perm_q,
  input  logic               boot_wr_en,
  input  logic               supply_low,
  input  logic               hold_rst,
  output logic [NUM_BLK-1:0] eff_lock,
  output logic               allow,
  output logic [7:0]         err,
  output logic               set_en,
  output logic               clr_en,
  output logic               perm_en
);

  // Effective lock: boot blocks are forced locked by a low protect level
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLK; gi++) begin : g_eff
      if (gi < NUM_BOOT) begin : g_boot
        assign eff_lock[gi] = lock_q[gi] | ~boot_wr_en;
      end else begin : g_plain
        assign eff_lock[gi] = lock_q[gi];
      end
    end
  endgenerate

  logic lock_hit;
  logic fire;

  always_comb begin
    unique case (op)
      OP_BYTE_WR, OP_BLK_ERASE:  lock_hit = eff_lock[idx];
      OP_CHIP_ERASE:             lock_hit = &eff_lock;
      OP_SET_LOCK, OP_CLR_LOCKS: lock_hit = perm_q;
      default:                   lock_hit = 1'b0;
    endcase

    if (hold_rst) begin
      allow = 1'b0;
      err   = 8'h00;
    end else if (supply_low) begin
      allow = 1'b0;
      err   = deny_code(op, ST_SUPPLY_BIT);
    end else if (lock_hit) begin
      allow = 1'b0;
      err   = deny_code(op, ST_LOCK_BIT);
    end else begin
      allow = 1'b1;
      err   = 8'h00;
    end

    fire    = req_valid && is_real_op(op) && allow;
    set_en  = fire && (op == OP_SET_LOCK);
    clr_en  = fire && (op == OP_CLR_LOCKS);
    perm_en = fire && (op == OP_SET_PERM);
  end

endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_BOOT  = 2,
  parameter int NUM_PARAM = 6,
  parameter int NUM_MAIN  = 15,
  parameter int SMALL_SH  = 13,
  parameter int BIG_SH    = 16,
  parameter logic [NUM_BOOT+NUM_PARAM+NUM_MAIN-1:0] LOCK_INIT = '0,
  parameter logic PERM_INIT = 1'b0,
  localparam int NUM_SMALL = NUM_BOOT + NUM_PARAM,
  localparam int NUM_BLK   = NUM_SMALL + NUM_MAIN,
  localparam int IDX_W     = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_rst,
  input  logic               supply_low,
  input  logic               boot_wr_en,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [ADDR_W-1:0]  id_addr,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic [7:0]         resp_err,
  output logic               id_lock,
  output logic               perm_lock,
  output logic [NUM_BLK-1:0] erasable
);

  op_e                op;
  logic [IDX_W-1:0]   req_idx, id_idx;
  logic               req_is_boot, id_is_boot;
  logic [NUM_BLK-1:0] lock_q, eff_lock;
  logic               perm_q;
  logic               dec_allow;
  logic [7:0]         dec_err;
  logic               set_en, clr_en, perm_en;
  logic               req_fire;

  assign op       = op_e'(req_op);
  assign req_fire = req_valid && is_real_op(op);

  wprot_blk_decode #(
    .ADDR_W(ADDR_W), .NUM_SMALL(NUM_SMALL), .NUM_BOOT(NUM_BOOT),
    .NUM_BLK(NUM_BLK), .SMALL_SH(SMALL_SH), .BIG_SH(BIG_SH)
  ) u_req_dec (
    .addr(req_addr), .idx(req_idx), .is_boot(req_is_boot)
  );

  wprot_blk_decode #(
    .ADDR_W(ADDR_W), .NUM_SMALL(NUM_SMALL), .NUM_BOOT(NUM_BOOT),
    .NUM_BLK(NUM_BLK), .SMALL_SH(SMALL_SH), .BIG_SH(BIG_SH)
  ) u_id_dec (
    .addr(id_addr), .idx(id_idx), .is_boot(id_is_boot)
  );

  wprot_lock_store #(
    .NUM_BLK(NUM_BLK), .LOCK_INIT(LOCK_INIT), .PERM_INIT(PERM_INIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(req_idx),
    .clr_en(clr_en), .perm_en(perm_en), .lock_q(lock_q), .perm_q(perm_q)
  );

  wprot_decide #(
    .NUM_BLK(NUM_BLK), .NUM_BOOT(NUM_BOOT)
  ) u_decide (
    .req_valid(req_valid), .op(op), .idx(req_idx), .lock_q(lock_q),
    .perm_q(perm_q), .boot_wr_en(boot_wr_en), .supply_low(supply_low),
    .hold_rst(hold_rst), .eff_lock(eff_lock), .allow(dec_allow),
    .err(dec_err), .set_en(set_en), .clr_en(clr_en), .perm_en(perm_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_err   <= 8'h00;
    end else begin
      resp_valid <= req_fire;
      if (req_fire) begin
        resp_allow <= dec_allow;
        resp_err   <= dec_err;
      end
    end
  end

  assign id_lock   = lock_q[id_idx];
  assign perm_lock = perm_q;
  assign erasable  = ~eff_lock;

  assert_allow_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_allow) |-> (resp_err == 8'h00));

  assert_hold_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && hold_rst) |=> (resp_valid && !resp_allow && resp_err == 8'h00));

  assert_supply_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !hold_rst && supply_low) |=> (!resp_allow && resp_err[ST_SUPPLY_BIT]));

  assert_boot_wp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && (op == OP_BYTE_WR || op == OP_BLK_ERASE) && req_is_boot && !boot_wr_en)
      |=> !resp_allow);

  assert_no_stray_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> !resp_valid);

endmodule

// File: tb/wprot_guard_tb.sv
module wprot_guard_tb;

  localparam int NB = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_rst = 1'b0, supply_low = 1'b0, boot_wr_en = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = '0, id_addr = '0;
  logic        resp_valid, resp_allow, id_lock, perm_lock;
  logic [7:0]  resp_err;
  logic [NB-1:0] erasable;

  int checks = 0, failures = 0;
  bit mlock [NB];
  bit mperm = 1'b0;

  wprot_guard u_dut (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .supply_low(supply_low),
    .boot_wr_en(boot_wr_en), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .id_addr(id_addr), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_err(resp_err), .id_lock(id_lock),
    .perm_lock(perm_lock), .erasable(erasable)
  );

  always #4 clk = ~clk;

  function automatic int blk_base(int i);
    return (i < 8) ? i * 8192 : (i - 7) * 65536;
  endfunction
  function automatic int blk_size(int i);
    return (i < 8) ? 8192 : 65536;
  endfunction
  function automatic int blk_of(int a);
    return (a < 65536) ? a / 8192 : 7 + a / 65536;
  endfunction
  function automatic bit eff(int i);
    return mlock[i] || (i < 2 && !boot_wr_en);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Expected {valid, allow, err}
  function automatic logic [9:0] expect_resp(int op, int a);
    bit er, hit, all;
    logic [7:0] e;
    if (op == 0 || op == 7) return 10'b0;
    er = (op == 2 || op == 3 || op == 5);
    all = 1'b1;
    for (int i = 0; i < NB; i++) all &= eff(i);
    case (op)
      1, 2:    hit = eff(blk_of(a));
      3:       hit = all;
      4, 5:    hit = mperm;
      default: hit = 1'b0;
    endcase
    if (hold_rst) return {2'b10, 8'h00};
    if (supply_low) begin e = er ? 8'h28 : 8'h18; return {2'b10, e}; end
    if (hit) begin e = er ? 8'h22 : 8'h12; return {2'b10, e}; end
    return {2'b11, 8'h00};
  endfunction

  task automatic run(int op, int a, string tag);
    logic [9:0] x;
    x = expect_resp(op, a);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = 20'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == x[9], {tag, " valid"}, resp_valid, x[9]);
    if (x[9]) chk({resp_allow, resp_err} == x[8:0], {tag, " allow/err"},
                  {resp_allow, resp_err}, x[8:0]);
    if (x[8]) begin
      if (op == 4) mlock[blk_of(a)] = 1'b1;
      if (op == 5) for (int i = 0; i < NB; i++) mlock[i] = 1'b0;
      if (op == 6) mperm = 1'b1;
    end
    @(negedge clk);
    chk(resp_valid == 1'b0, "R3 single-cycle valid", resp_valid, 0);
  endtask

  task automatic check_ids(string tag);
    logic [NB-1:0] ev;
    for (int i = 0; i < NB; i++) begin
      id_addr = 20'(blk_base(i)); #1;
      chk(id_lock == mlock[i], {tag, " R1 id_lock low end"}, id_lock, mlock[i]);
      id_addr = 20'(blk_base(i) + blk_size(i) - 1); #1;
      chk(id_lock == mlock[i], {tag, " R1 id_lock high end"}, id_lock, mlock[i]);
      ev[i] = ~eff(i);
    end
    chk(erasable == ev, {tag, " R10 erasable"}, erasable, ev);
    chk(perm_lock == mperm, {tag, " R9 perm_lock"}, perm_lock, mperm);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < NB; i++) mlock[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(resp_valid == 1'b0, "R2 resp_valid after reset", resp_valid, 0);
    chk(perm_lock == 1'b0, "R2 perm after reset", perm_lock, 0);
    check_ids("R2 reset");

    // R8 set locks on every third block, R1 decode at the block middle
    for (int i = 0; i < NB; i += 3) run(4, blk_base(i) + blk_size(i) / 2, "R8 set-lock");
    check_ids("R8 after set");

    // R4 R5 writes/erases everywhere under both protect levels
    for (int w = 0; w < 2; w++) begin
      boot_wr_en = w[0];
      for (int i = 0; i < NB; i++) begin
        run(1, blk_base(i), "R4 R5 byte write");
        run(2, blk_base(i) + blk_size(i) - 1, "R4 R5 block erase");
      end
      check_ids("R5 protect level");
      run(3, 0, "R10 chip erase partial");
    end

    // R6 supply low on all ops
    supply_low = 1'b1;
    for (int op = 1; op <= 6; op++) run(op, 20'h0A123, "R6 supply low");
    check_ids("R6 no change");

    // R7 device reset wins over supply low
    hold_rst = 1'b1;
    for (int op = 1; op <= 6; op++) run(op, 20'h02345, "R7 hold reset");
    supply_low = 1'b0;
    for (int op = 1; op <= 6; op++) run(op, 20'hF0000, "R7 hold reset only");
    hold_rst = 1'b0;
    check_ids("R7 no change");

    // R3 reserved codes
    run(0, 20'h00000, "R3 code 0");
    run(7, 20'h40000, "R3 code 7");
    check_ids("R3 no change");

    // R10 lock all non-boot blocks, leave block 1 open
    for (int i = 2; i < NB; i++) run(4, blk_base(i), "R8 set-lock all");
    boot_wr_en = 1'b0;
    check_ids("R10 wp low");
    run(3, 20'h12345, "R10 chip erase all locked");
    boot_wr_en = 1'b1;
    run(3, 20'h12345, "R10 chip erase boot1 open");
    run(1, 20'h03FFF, "R5 boot1 follows bit");

    // R8 clear all
    run(5, 20'h77777, "R8 clear-locks");
    check_ids("R8 after clear");

    // R9 permanent lock
    run(4, blk_base(9), "R8 set before perm");
    run(6, 20'h00003, "R9 set perm");
    run(4, blk_base(5), "R9 set-lock denied");
    run(5, 20'h00000, "R9 clear denied");
    run(6, 20'h00003, "R9 set perm again");
    check_ids("R9 frozen");

    report();
  end

endmodule